// File: doc/BRIEF.md
# Double-Word Operand Fetch Unit

This block gathers a 64-bit source operand for a floating-point datapath. A 6-bit effective-address field picks how the operand is located. Memory operands are read as two 32-bit beats, the high half first. Immediate operands are taken from the instruction stream as 16-bit extension words. Absolute-long addresses are built from two extension words. Post-increment and pre-decrement modes write the adjusted address register back as a side effect.

A controller pulses `start` together with the field. The block reads the selected address register combinationally through a read port. Displacement, indexed and PC-relative addresses come in already computed on `calc_addr`. The block then drives a single-outstanding memory read port and an extension-word port. It ends with a one-cycle `done`, with the 64-bit value or an error flag.

Top module: `dword_operand_fetch`

## Requirements
- R1: After reset the block is idle: `done`, `mem_req`, `ext_req` and `areg_wr_en` are all low.
- R2: The mode is `ea_field[5:3]` and the register number is `ea_field[2:0]`. The register number drives `areg_rd_idx` while `start` is high, and it also drives `areg_wr_idx` on any write-back.
- R3: Every memory operand is read as two acknowledged beats, at address A and then at A+4. The first word becomes `result[63:32]` and the second word becomes `result[31:0]`. `done` is high for exactly one cycle per operation.
- R4: In mode 2, A is the selected address register, and no register write-back happens.
- R5: In mode 3, A is the register's current value, and the register is written back with that value plus 8.
- R6: In mode 4, the register is written back with its value minus 8, and A is that new value.
- R7: Modes 5 and 6, and mode 7 with register numbers 2 or 3, take A from `calc_addr`, with no write-back.
- R8: Mode 7 with register number 1 consumes two extension words. The first word forms bits 31:16 of A and the second forms bits 15:0.
- R9: Mode 7 with register number 4 consumes four extension words, most significant first, into `result`. It makes no memory request.
- R10: Any other combination (modes 0 and 1, and mode 7 with register numbers 0, 5, 6 or 7) gives `done` with `err` high. It makes no memory request, no extension request and no write-back.
- R11: While `mem_ack` is low, `mem_req` and `mem_addr` hold steady. The register write-back happens exactly once per operation, however long the memory stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| ea_field | input | 6 | Mode and register number |
| calc_addr | input | 32 | Precomputed displacement/index/PC address |
| areg_rd_idx | output | 3 | Address register read index |
| areg_rd_data | input | 32 | Address register read value |
| areg_wr_en | output | 1 | Address register write strobe |
| areg_wr_idx | output | 3 | Address register write index |
| areg_wr_data | output | 32 | Address register write value |
| ext_req | output | 1 | Extension word wanted |
| ext_vld | input | 1 | Extension word present |
| ext_word | input | 16 | Extension word from the instruction stream |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read completes this cycle |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Unsupported mode, valid with done |
| result | output | 64 | Assembled operand, valid with done |

## Verification
The bench sweeps all 64 field encodings twice: once with memory that answers at once and once with memory that stalls two cycles per beat. The address registers carry values that change from one operation to the next through the write-backs. These sweeps separate the base-address source of each mode, the sign of the write-back step, the beat order against the word order, and the bad encodings against the good ones. Extension words carry a different pattern per encoding, so a swapped or dropped half shows up in the absolute-long and immediate results.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    OPK_AIND, OPK_POST, OPK_PRE, OPK_CALC, OPK_ABS, OPK_IMM, OPK_BAD
  } opk_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXT, ST_HI, ST_LO, ST_DONE
  } st_e;
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [5:0] ea_field,
  output opk_e       kind
);
  logic [2:0] mode;
  logic [2:0] rnum;

  assign mode = ea_field[5:3];
  assign rnum = ea_field[2:0];

  always_comb begin
    kind = OPK_BAD;
    case (mode)
      3'd2: kind = OPK_AIND;
      3'd3: kind = OPK_POST;
      3'd4: kind = OPK_PRE;
      3'd5, 3'd6: kind = OPK_CALC;
      3'd7: begin
        case (rnum)
          3'd1:       kind = OPK_ABS;
          3'd2, 3'd3: kind = OPK_CALC;
          3'd4:       kind = OPK_IMM;
          default:    kind = OPK_BAD;
        endcase
      end
      default: kind = OPK_BAD;
    endcase
  end
endmodule

// File: rtl/opf_extbuf.sv
module opf_extbuf #(
  parameter int EW = 16,
  parameter int BW = 64,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [EW-1:0] word,
  output logic [BW-1:0] data_q,
  output logic [BW-1:0] data_nxt,
  output logic [CW-1:0] cnt_q
);
  logic [BW-1:0] data_d;
  logic [CW-1:0] cnt_d;

  assign data_nxt = {data_q[BW-EW-1:0], word};

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr) begin
      data_d = '0;
      cnt_d  = '0;
    end else if (shift) begin
      data_d = data_nxt;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dword_operand_fetch.sv
module dword_operand_fetch
  import opf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int WW   = 32,
  parameter int EW   = 16,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    ea_field,
  input  logic [AW-1:0] calc_addr,
  output logic [2:0]    areg_rd_idx,
  input  logic [AW-1:0] areg_rd_data,
  output logic          areg_wr_en,
  output logic [2:0]    areg_wr_idx,
  output logic [AW-1:0] areg_wr_data,
  output logic          ext_req,
  input  logic          ext_vld,
  input  logic [EW-1:0] ext_word,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic [2*WW-1:0] result
);
  localparam int OW        = 2 * WW;
  localparam int IMM_WORDS = OW / EW;
  localparam int ABS_WORDS = AW / EW;
  localparam int CW        = $clog2(IMM_WORDS + 1);
  localparam int BEAT      = WW / 8;

  st_e             state_q, state_d;
  opk_e            kind_q, kind_d, kind_now;
  logic [AW-1:0]   base_q, base_d;
  logic [WW-1:0]   hi_q, hi_d;
  logic [OW-1:0]   res_q, res_d;
  logic            err_q, err_d;
  logic            accept;
  logic            ext_shift;
  logic [OW-1:0]   ext_data, ext_next;
  logic [CW-1:0]   ext_cnt, ext_need;

  opf_decode u_decode (
    .ea_field (ea_field),
    .kind     (kind_now)
  );

  assign accept    = start && (state_q == ST_IDLE);
  assign ext_shift = (state_q == ST_EXT) && ext_vld;
  assign ext_need  = (kind_q == OPK_IMM) ? CW'(IMM_WORDS) : CW'(ABS_WORDS);

  opf_extbuf #(.EW(EW), .BW(OW), .CW(CW)) u_extbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .shift    (ext_shift),
    .word     (ext_word),
    .data_q   (ext_data),
    .data_nxt (ext_next),
    .cnt_q    (ext_cnt)
  );

  assign areg_rd_idx  = ea_field[2:0];
  assign areg_wr_idx  = ea_field[2:0];
  assign areg_wr_en   = accept && ((kind_now == OPK_POST) || (kind_now == OPK_PRE));
  assign areg_wr_data = (kind_now == OPK_POST) ? (areg_rd_data + AW'(STEP))
                                               : (areg_rd_data - AW'(STEP));

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    base_d  = base_q;
    hi_d    = hi_q;
    res_d   = res_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          kind_d = kind_now;
          err_d  = 1'b0;
          case (kind_now)
            OPK_AIND, OPK_POST: begin
              base_d  = areg_rd_data;
              state_d = ST_HI;
            end
            OPK_PRE: begin
              base_d  = areg_rd_data - AW'(STEP);
              state_d = ST_HI;
            end
            OPK_CALC: begin
              base_d  = calc_addr;
              state_d = ST_HI;
            end
            OPK_ABS, OPK_IMM: state_d = ST_EXT;
            default: begin
              err_d   = 1'b1;
              res_d   = '0;
              state_d = ST_DONE;
            end
          endcase
        end
      end
      ST_EXT: begin
        if (ext_vld && (ext_cnt + CW'(1) == ext_need)) begin
          if (kind_q == OPK_IMM) begin
            res_d   = ext_next;
            state_d = ST_DONE;
          end else begin
            base_d  = ext_next[AW-1:0];
            state_d = ST_HI;
          end
        end
      end
      ST_HI: begin
        if (mem_ack) begin
          hi_d    = mem_rdata;
          state_d = ST_LO;
        end
      end
      ST_LO: begin
        if (mem_ack) begin
          res_d   = {hi_q, mem_rdata};
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= OPK_BAD;
      base_q  <= '0;
      hi_q    <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      base_q  <= base_d;
      hi_q    <= hi_d;
      res_q   <= res_d;
      err_q   <= err_d;
    end
  end

  assign mem_req  = (state_q == ST_HI) || (state_q == ST_LO);
  assign mem_addr = (state_q == ST_LO) ? (base_q + AW'(BEAT)) : base_q;
  assign ext_req  = (state_q == ST_EXT);
  assign done     = (state_q == ST_DONE);
  assign err      = err_q;
  assign result   = res_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11
  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(BEAT))); // R3
  AST_SINGLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    areg_wr_en |=> !areg_wr_en); // R11
  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == OPK_IMM) |-> !mem_req); // R9
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_now == OPK_BAD) |=> (done && err && !mem_req && !ext_req)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
endmodule

// File: tb/dword_operand_fetch_bench.sv
module dword_operand_fetch_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  ea_field = '0;
  logic [31:0] calc_addr = '0;
  logic [2:0]  areg_rd_idx;
  logic [31:0] areg_rd_data;
  logic        areg_wr_en;
  logic [2:0]  areg_wr_idx;
  logic [31:0] areg_wr_data;
  logic        ext_req;
  logic        ext_vld = 1'b0;
  logic [15:0] ext_word = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic        err;
  logic [63:0] result;

  logic [31:0] areg [8];
  logic [15:0] ext_mem [4];
  int ext_ptr, stall_cycles, stall_cnt;
  int beats, wb_cnt, ext_used;
  logic [31:0] addr0, addr1, wb_val;
  logic [2:0]  wb_idx;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  dword_operand_fetch u_dword_operand_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .ea_field(ea_field), .calc_addr(calc_addr),
    .areg_rd_idx(areg_rd_idx), .areg_rd_data(areg_rd_data),
    .areg_wr_en(areg_wr_en), .areg_wr_idx(areg_wr_idx), .areg_wr_data(areg_wr_data),
    .ext_req(ext_req), .ext_vld(ext_vld), .ext_word(ext_word),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .err(err), .result(result)
  );

  assign areg_rd_data = areg[areg_rd_idx];

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req) begin
      if (stall_cnt >= stall_cycles) begin
        mem_ack   = 1'b1;
        mem_rdata = memfn(mem_addr);
        stall_cnt = 0;
      end else begin
        mem_ack = 1'b0;
        stall_cnt++;
      end
    end else begin
      mem_ack   = 1'b0;
      stall_cnt = 0;
    end
    ext_vld  = ext_req;
    ext_word = ext_mem[ext_ptr % 4];
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (beats == 0) addr0 = mem_addr;
      else addr1 = mem_addr;
      beats++;
    end
    if (ext_req && ext_vld) begin
      ext_ptr++;
      ext_used++;
    end
    if (areg_wr_en) begin
      wb_cnt++;
      wb_idx = areg_wr_idx;
      wb_val = areg_wr_data;
      areg[areg_wr_idx] = areg_wr_data;
    end
  end

  task automatic run_op(input logic [5:0] ea, input logic [31:0] cval);
    logic [2:0]  mode = ea[5:3];
    logic [2:0]  r = ea[2:0];
    logic [31:0] an = areg[ea[2:0]];
    logic [31:0] a = '0;
    logic        bad = 1'b0, imm = 1'b0, wb = 1'b0;
    logic [31:0] wbv = '0;
    logic [63:0] exp_res;
    int          need_ext = 0;
    int          cyc = 0;
    for (int k = 0; k < 4; k++)
      ext_mem[k] = 16'hA000 + 16'(k * 16'h0111) + {10'b0, ea} + 16'(stall_cycles << 8);
    case (mode)
      3'd2: a = an;
      3'd3: begin a = an; wb = 1'b1; wbv = an + 32'd8; end
      3'd4: begin a = an - 32'd8; wb = 1'b1; wbv = a; end
      3'd5, 3'd6: a = cval;
      3'd7: begin
        case (r)
          3'd1: begin a = {ext_mem[0], ext_mem[1]}; need_ext = 2; end
          3'd2, 3'd3: a = cval;
          3'd4: begin imm = 1'b1; need_ext = 4; end
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
    exp_res = imm ? {ext_mem[0], ext_mem[1], ext_mem[2], ext_mem[3]} : {memfn(a), memfn(a + 32'd4)};
    beats = 0; wb_cnt = 0; ext_ptr = 0; ext_used = 0;
    start = 1'b1; ea_field = ea; calc_addr = cval;
    #1;
    chk(areg_rd_idx == r, "R2 rd_idx", 64'(areg_rd_idx), 64'(r));
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R3 done reached", 64'(done), 64'd1);
    chk(err == bad, bad ? "R10 err" : "R3 err low", 64'(err), 64'(bad));
    if (bad) begin
      chk(beats == 0 && ext_used == 0 && wb_cnt == 0, "R10 quiet",
          64'(beats + ext_used + wb_cnt), 64'd0);
    end else begin
      chk(result == exp_res, imm ? "R9 imm value" : "R3 result", result, exp_res);
      chk(ext_used == need_ext, need_ext == 2 ? "R8 ext words" : "R9 ext words",
          64'(ext_used), 64'(need_ext));
      if (imm) begin
        chk(beats == 0, "R9 no memory", 64'(beats), 64'd0);
      end else begin
        chk(beats == 2, "R3 beats", 64'(beats), 64'd2);
        chk(addr0 == a, mode == 3'd4 ? "R6 addr" : (mode == 3'd3 ? "R5 addr" :
            (mode == 3'd2 ? "R4 addr" : (need_ext == 2 ? "R8 addr" : "R7 addr"))),
            64'(addr0), 64'(a));
        chk(addr1 == a + 32'd4, "R3 second addr", 64'(addr1), 64'(a + 32'd4));
      end
      chk(wb_cnt == (wb ? 1 : 0), wb ? "R11 single write-back" : "R4 R7 no write-back",
          64'(wb_cnt), 64'(wb ? 1 : 0));
      if (wb) begin
        chk(wb_val == wbv && wb_idx == r, mode == 3'd3 ? "R5 write-back" : "R6 write-back",
            {29'd0, wb_idx, wb_val}, {29'd0, r, wbv});
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R3 done pulse", 64'(done), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) areg[i] = 32'h0001_0000 + 32'(i) * 32'h0000_0130;
    ext_ptr = 0; stall_cycles = 0; stall_cnt = 0;
    beats = 0; wb_cnt = 0; ext_used = 0;
    addr0 = '0; addr1 = '0; wb_val = '0; wb_idx = '0;
    for (int k = 0; k < 4; k++) ext_mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !ext_req && !areg_wr_en, "R1 reset idle",
        {60'd0, done, mem_req, ext_req, areg_wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && !ext_req, "R1 idle after release",
        {61'd0, done, mem_req, ext_req}, 64'd0);
    for (int s = 0; s < 2; s++) begin
      stall_cycles = s * 2;
      for (int e = 0; e < 64; e++)
        run_op(6'(e), 32'h0002_0040 + 32'(e) * 32'h0000_0104 + 32'(s) * 32'h10);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule